// File: doc/BRIEF.md
# SPI Controller Interrupt and FIFO Register File

This block is the software-facing register file of a command-driven SPI controller. Software writes instruction words and transmit data into two FIFOs, reads received data out of a third, and watches interrupt state. The state covers FIFO watermarks and the completion of sync instructions. The instruction sequencer and the serial wire logic sit outside the block. They drain the command and transmit FIFOs through show-ahead valid/read handshakes, fill the receive FIFO through a ready/write handshake, and report sync completions as a one-cycle pulse that carries an 8-bit identifier.

The register bus is a simple 32-bit bus with word addresses. Every read is answered one cycle later with a valid strobe. Reading the receive pop window removes the head entry. Reading the peek window only looks at it. A soft-reset register holds the engine side in reset and empties all three FIFOs. It is set on power-up, so software must clear it before use.

Pending interrupt bits are set by hardware and cleared by writing ones. The watermark bits are set again on every cycle in which their level condition holds. The interrupt line is the OR of the pending bits gated by the enable register.

Top module: `spi_ctl_regfile`

## Requirements
- R1: After the synchronous reset, these values hold: the soft-reset bit reads 1 and `eng_reset` is high, the enable register reads 0, the sync identifier reads 0, both room registers read the full depth (16 by default), the receive level reads 0 and `irq` is low.
- R2: Word address 0x10, bit 0, is the soft-reset control and drives `eng_reset`. While it is 1, all three FIFOs are emptied and every push into them is discarded. Writing 0 releases it.
- R3: Word 0x34 reads the free entries of the command FIFO, word 0x35 the free entries of the transmit FIFO, and word 0x36 the fill level of the receive FIFO. A push into a full FIFO is dropped.
- R4: A write to word 0x38 pushes bits [15:0] into the command FIFO. A write to word 0x39 pushes all 32 bits into the transmit FIFO. Each FIFO presents its entries on the engine side in push order. A read strobe on an empty FIFO has no effect.
- R5: A read of word 0x3A returns the receive head and removes it. A read of word 0x3B returns the head and leaves the level unchanged. Either read of an empty receive FIFO returns 0.
- R6: Pending bits (word 0x21) are: bit 0 when the command level is at most CMD_AE (default 4), bit 1 when the transmit level is at most TX_AE (default 4), bit 2 when the receive level is at least RX_AF (default 12), and bit 3 on a sync event. The level conditions are sampled every cycle.
- R7: Writing to word 0x21 clears each pending bit whose data bit is 1. A hardware set in the same cycle wins over the clear.
- R8: Word 0x20 bits [3:0] are the interrupt enables and read back as written. Word 0x22 reads pending AND enable.
- R9: `irq` is high exactly when some enabled pending bit was set in the previous cycle.
- R10: A `sync_evt` pulse latches `sync_id` into word 0x30 (bits [7:0]) and sets pending bit 3.
- R11: `bus_rvalid` and `bus_rdata` are updated on the clock edge after `bus_rd`. Unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 6 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| bus_rvalid | output | 1 | Read data valid, one cycle after `bus_rd` |
| irq | output | 1 | Interrupt request |
| eng_reset | output | 1 | Engine reset from the soft-reset register |
| cmd_valid | output | 1 | Command FIFO holds an entry |
| cmd_rd | input | 1 | Engine takes the command head |
| cmd_data | output | 16 | Command FIFO head |
| tx_valid | output | 1 | Transmit FIFO holds an entry |
| tx_rd | input | 1 | Engine takes the transmit head |
| tx_data | output | 32 | Transmit FIFO head |
| rx_ready | output | 1 | Receive FIFO accepts a write |
| rx_wr | input | 1 | Engine writes a received word |
| rx_wdata | input | 32 | Received word |
| sync_evt | input | 1 | Sync instruction completed (one-cycle pulse) |
| sync_id | input | 8 | Identifier of the completed sync |

## Verification
A corrupted FIFO pointer or count shows up at the next room or level read. It also shows up as out-of-order or repeated heads on the engine side, at the next pop. A pending bit that misses its set, or a clear that wins over a hardware set, becomes visible one read later in the pending or source word. It reaches `irq` two cycles after the cause. A peek that pops by mistake changes the receive level at the next level read, so the bench mixes random pushes and pops with level reads, peeks and directed watermark crossings.

// File: rtl/spi_regs_pkg.sv
package spi_regs_pkg;
  localparam int BUS_W  = 32;
  localparam int ADDR_W = 6;
  localparam int IRQ_N  = 4;

  localparam logic [ADDR_W-1:0] A_SOFTRST = 6'h10;
  localparam logic [ADDR_W-1:0] A_IRQ_EN  = 6'h20;
  localparam logic [ADDR_W-1:0] A_IRQ_PND = 6'h21;
  localparam logic [ADDR_W-1:0] A_IRQ_SRC = 6'h22;
  localparam logic [ADDR_W-1:0] A_SYNC_ID = 6'h30;
  localparam logic [ADDR_W-1:0] A_CMD_ROOM = 6'h34;
  localparam logic [ADDR_W-1:0] A_TX_ROOM  = 6'h35;
  localparam logic [ADDR_W-1:0] A_RX_LEVEL = 6'h36;
  localparam logic [ADDR_W-1:0] A_CMD_PUSH = 6'h38;
  localparam logic [ADDR_W-1:0] A_TX_PUSH  = 6'h39;
  localparam logic [ADDR_W-1:0] A_RX_POP   = 6'h3A;
  localparam logic [ADDR_W-1:0] A_RX_PEEK  = 6'h3B;

  localparam int IRQ_CMD_LOW = 0;
  localparam int IRQ_TX_LOW  = 1;
  localparam int IRQ_RX_HIGH = 2;
  localparam int IRQ_SYNC    = 3;
endpackage

// File: rtl/sreg_fifo.sv
module sreg_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          flush,
  input  logic          push,
  input  logic [W-1:0]  wdata,
  input  logic          pop,
  output logic [W-1:0]  rdata,
  output logic          empty,
  output logic          full,
  output logic [CW-1:0] count
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic          push_ok, pop_ok;

  assign empty   = (count == '0);
  assign full    = (count == CW'(DEPTH));
  assign push_ok = push && !full && !flush;
  assign pop_ok  = pop && !empty && !flush;
  assign rdata   = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push_ok) wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      if (pop_ok)  rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      case ({push_ok, pop_ok})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  // R3: occupancy never exceeds the depth
  p_count_bound_r3: assert property (@(posedge clk) disable iff (rst)
    count <= CW'(DEPTH));
  // R3: a push into a full FIFO without a pop leaves the level unchanged
  p_full_drop_r3: assert property (@(posedge clk) disable iff (rst)
    (full && push && !pop && !flush) |=> $stable(count));
  // R4: a read strobe on an empty FIFO does not change the level
  p_empty_pop_r4: assert property (@(posedge clk) disable iff (rst)
    (empty && pop && !push) |=> (count == '0));
endmodule

// File: rtl/spi_irq_ctrl.sv
module spi_irq_ctrl #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set_i,
  input  logic         clr_wr,
  input  logic [N-1:0] clr_mask,
  input  logic         en_wr,
  input  logic [N-1:0] en_data,
  output logic [N-1:0] pend,
  output logic [N-1:0] en,
  output logic         irq
);
  logic [N-1:0] clr_eff;

  assign clr_eff = clr_wr ? clr_mask : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend <= '0;
      en   <= '0;
      irq  <= 1'b0;
    end else begin
      pend <= (pend & ~clr_eff) | set_i;
      if (en_wr) en <= en_data;
      irq  <= |(pend & en);
    end
  end

  // R7: hardware set wins over a simultaneous clear
  p_set_wins_r7: assert property (@(posedge clk) disable iff (rst)
    (|set_i) |=> ((pend & $past(set_i)) == $past(set_i)));
  // R7: cleared bits without a concurrent set read as zero
  p_clear_r7: assert property (@(posedge clk) disable iff (rst)
    clr_wr |=> ((pend & $past(clr_mask & ~set_i)) == '0));
  // R9: with all enables off the line stays low on the next cycle
  p_irq_off_r9: assert property (@(posedge clk) disable iff (rst)
    (en == '0) |=> !irq);
endmodule

// File: rtl/spi_ctl_regfile.sv
module spi_ctl_regfile
  import spi_regs_pkg::*;
#(
  parameter int CMD_DEPTH = 16,
  parameter int TX_DEPTH  = 16,
  parameter int RX_DEPTH  = 16,
  parameter int CMD_W     = 16,
  parameter int ID_W      = 8,
  parameter int CMD_AE    = CMD_DEPTH / 4,
  parameter int TX_AE     = TX_DEPTH / 4,
  parameter int RX_AF     = (RX_DEPTH * 3) / 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  output logic              bus_rvalid,
  output logic              irq,
  output logic              eng_reset,
  output logic              cmd_valid,
  input  logic              cmd_rd,
  output logic [CMD_W-1:0]  cmd_data,
  output logic              tx_valid,
  input  logic              tx_rd,
  output logic [BUS_W-1:0]  tx_data,
  output logic              rx_ready,
  input  logic              rx_wr,
  input  logic [BUS_W-1:0]  rx_wdata,
  input  logic              sync_evt,
  input  logic [ID_W-1:0]   sync_id
);
  localparam int CMD_CW = $clog2(CMD_DEPTH + 1);
  localparam int TX_CW  = $clog2(TX_DEPTH + 1);
  localparam int RX_CW  = $clog2(RX_DEPTH + 1);

  logic              eng_rst_q;
  logic [ID_W-1:0]   sync_q;
  logic              cmd_empty, cmd_full, tx_empty, tx_full, rx_empty, rx_full;
  logic [CMD_CW-1:0] cmd_cnt;
  logic [TX_CW-1:0]  tx_cnt;
  logic [RX_CW-1:0]  rx_cnt;
  logic [BUS_W-1:0]  rx_head;
  logic              cmd_push, tx_push, rx_pop;
  logic [IRQ_N-1:0]  irq_set, pend, en;

  assign eng_reset = eng_rst_q;
  assign cmd_push  = bus_wr && (bus_addr == A_CMD_PUSH);
  assign tx_push   = bus_wr && (bus_addr == A_TX_PUSH);
  assign rx_pop    = bus_rd && (bus_addr == A_RX_POP);
  assign cmd_valid = !cmd_empty;
  assign tx_valid  = !tx_empty;
  assign rx_ready  = !rx_full && !eng_rst_q;

  sreg_fifo #(.W(CMD_W), .DEPTH(CMD_DEPTH)) u_cmd_fifo (
    .clk(clk), .rst(rst), .flush(eng_rst_q),
    .push(cmd_push), .wdata(bus_wdata[CMD_W-1:0]),
    .pop(cmd_rd), .rdata(cmd_data),
    .empty(cmd_empty), .full(cmd_full), .count(cmd_cnt));

  sreg_fifo #(.W(BUS_W), .DEPTH(TX_DEPTH)) u_tx_fifo (
    .clk(clk), .rst(rst), .flush(eng_rst_q),
    .push(tx_push), .wdata(bus_wdata),
    .pop(tx_rd), .rdata(tx_data),
    .empty(tx_empty), .full(tx_full), .count(tx_cnt));

  sreg_fifo #(.W(BUS_W), .DEPTH(RX_DEPTH)) u_rx_fifo (
    .clk(clk), .rst(rst), .flush(eng_rst_q),
    .push(rx_wr), .wdata(rx_wdata),
    .pop(rx_pop), .rdata(rx_head),
    .empty(rx_empty), .full(rx_full), .count(rx_cnt));

  assign irq_set[IRQ_CMD_LOW] = (cmd_cnt <= CMD_CW'(CMD_AE));
  assign irq_set[IRQ_TX_LOW]  = (tx_cnt <= TX_CW'(TX_AE));
  assign irq_set[IRQ_RX_HIGH] = (rx_cnt >= RX_CW'(RX_AF));
  assign irq_set[IRQ_SYNC]    = sync_evt;

  spi_irq_ctrl #(.N(IRQ_N)) u_irq (
    .clk(clk), .rst(rst), .set_i(irq_set),
    .clr_wr(bus_wr && (bus_addr == A_IRQ_PND)),
    .clr_mask(bus_wdata[IRQ_N-1:0]),
    .en_wr(bus_wr && (bus_addr == A_IRQ_EN)),
    .en_data(bus_wdata[IRQ_N-1:0]),
    .pend(pend), .en(en), .irq(irq));

  always_ff @(posedge clk) begin
    if (rst) begin
      eng_rst_q <= 1'b1;
      sync_q    <= '0;
    end else begin
      if (bus_wr && (bus_addr == A_SOFTRST)) eng_rst_q <= bus_wdata[0];
      if (sync_evt) sync_q <= sync_id;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rvalid <= 1'b0;
      bus_rdata  <= '0;
    end else begin
      bus_rvalid <= bus_rd;
      if (bus_rd) begin
        case (bus_addr)
          A_SOFTRST:  bus_rdata <= BUS_W'(eng_rst_q);
          A_IRQ_EN:   bus_rdata <= BUS_W'(en);
          A_IRQ_PND:  bus_rdata <= BUS_W'(pend);
          A_IRQ_SRC:  bus_rdata <= BUS_W'(pend & en);
          A_SYNC_ID:  bus_rdata <= BUS_W'(sync_q);
          A_CMD_ROOM: bus_rdata <= BUS_W'(CMD_CW'(CMD_DEPTH) - cmd_cnt);
          A_TX_ROOM:  bus_rdata <= BUS_W'(TX_CW'(TX_DEPTH) - tx_cnt);
          A_RX_LEVEL: bus_rdata <= BUS_W'(rx_cnt);
          A_RX_POP,
          A_RX_PEEK:  bus_rdata <= rx_empty ? '0 : rx_head;
          default:    bus_rdata <= '0;
        endcase
      end
    end
  end

  // R2: soft reset leaves every FIFO empty on the following cycle
  p_softrst_flush_r2: assert property (@(posedge clk) disable iff (rst)
    eng_rst_q |=> (cmd_cnt == '0 && tx_cnt == '0 && rx_cnt == '0));
  // R5: a peek read does not change the receive level
  p_peek_keeps_r5: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr == A_RX_PEEK && !rx_wr) |=> $stable(rx_cnt));
  // R10: the sync identifier is captured on the event
  p_sync_latch_r10: assert property (@(posedge clk) disable iff (rst)
    sync_evt |=> (sync_q == $past(sync_id) && pend[IRQ_SYNC]));
  // R11: every read strobe is answered on the next cycle
  p_rvalid_r11: assert property (@(posedge clk) disable iff (rst)
    bus_rd |=> bus_rvalid);
endmodule

// File: tb/tb_spi_ctl_regfile.sv
module tb_spi_ctl_regfile;
  localparam int D = 16;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_rvalid, irq, eng_reset;
  logic        cmd_valid, cmd_rd = 1'b0;
  logic [15:0] cmd_data;
  logic        tx_valid, tx_rd = 1'b0;
  logic [31:0] tx_data;
  logic        rx_ready, rx_wr = 1'b0;
  logic [31:0] rx_wdata = '0;
  logic        sync_evt = 1'b0;
  logic [7:0]  sync_id = '0;

  int nchk = 0, nfail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  spi_ctl_regfile dut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
    .irq(irq), .eng_reset(eng_reset), .cmd_valid(cmd_valid), .cmd_rd(cmd_rd),
    .cmd_data(cmd_data), .tx_valid(tx_valid), .tx_rd(tx_rd), .tx_data(tx_data),
    .rx_ready(rx_ready), .rx_wr(rx_wr), .rx_wdata(rx_wdata),
    .sync_evt(sync_evt), .sync_id(sync_id));

  function automatic logic [31:0] exp_room(int n);
    return 32'(D - n);
  endfunction

  function automatic logic [31:0] exp_wm(int cmd_n, int tx_n, int rx_n);
    return {29'd0, rx_n >= 12, tx_n <= 4, cmd_n <= 4};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
    nchk++;
    if (bus_rvalid !== 1'b1) begin
      nfail++;
      $display("FAIL R11 rvalid actual=%0b expected=1", bus_rvalid);
    end
  endtask

  task automatic cmd_take(output logic v, output logic [15:0] d);
    @(negedge clk);
    v = cmd_valid; d = cmd_data;
    cmd_rd = 1'b1;
    @(negedge clk);
    cmd_rd = 1'b0;
  endtask

  task automatic rx_put(input logic [31:0] d);
    @(negedge clk);
    rx_wr = 1'b1; rx_wdata = d;
    @(negedge clk);
    rx_wr = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL R11 watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    logic        v;
    logic [15:0] cd;
    logic [15:0] cq[$];
    logic [31:0] rq[$];
    void'($urandom(32'd4242));

    idle(4);
    rst = 1'b0;
    idle(1);
    // R1 reset state
    chk("R1 eng_reset", 32'(eng_reset), 32'd1);
    chk("R1 irq", 32'(irq), 32'd0);
    rd(6'h10, r); chk("R1 softrst", r, 32'd1);
    rd(6'h20, r); chk("R1 enable", r, 32'd0);
    rd(6'h30, r); chk("R1 sync id", r, 32'd0);
    rd(6'h34, r); chk("R1 cmd room", r, exp_room(0));
    rd(6'h35, r); chk("R1 tx room", r, exp_room(0));
    rd(6'h36, r); chk("R1 rx level", r, 32'd0);
    // R11 unmapped
    rd(6'h00, r); chk("R11 unmapped", r, 32'd0);
    wr(6'h05, 32'hFFFF_FFFF);
    rd(6'h05, r); chk("R11 unmapped after write", r, 32'd0);

    // R2 pushes dropped in soft reset
    wr(6'h38, 32'h1234);
    rx_put(32'h55);
    rd(6'h34, r); chk("R2 cmd room held", r, exp_room(0));
    rd(6'h36, r); chk("R2 rx level held", r, 32'd0);
    wr(6'h10, 32'd0);
    rd(6'h10, r); chk("R2 softrst released", r, 32'd0);
    chk("R2 eng_reset low", 32'(eng_reset), 32'd0);

    // R6 pending after release: cmd and tx low
    idle(2);
    rd(6'h21, r); chk("R6 pending empty fifos", r, exp_wm(0, 0, 0));

    // R7 clear and set priority
    for (int i = 0; i < 5; i++) begin
      wr(6'h38, 32'(16'hA000 + i)); cq.push_back(16'(16'hA000 + i));
    end
    idle(2);
    wr(6'h21, 32'h1);
    idle(2);
    rd(6'h21, r); chk("R7 cleared cmd bit", r, 32'h2);
    wr(6'h21, 32'h2);
    idle(2);
    rd(6'h21, r); chk("R7 hw set wins", r, 32'h2);

    // R8 / R9 enable and source
    wr(6'h20, 32'h1);
    rd(6'h20, r); chk("R8 enable readback", r, 32'h1);
    rd(6'h22, r); chk("R8 source masked", r, 32'h0);
    idle(3);
    chk("R9 irq low", 32'(irq), 32'd0);
    wr(6'h20, 32'h3);
    rd(6'h22, r); chk("R8 source", r, 32'h2);
    idle(3);
    chk("R9 irq high", 32'(irq), 32'd1);
    wr(6'h20, 32'h0);
    idle(3);
    chk("R9 irq off", 32'(irq), 32'd0);

    // R4 command order
    while (cq.size() > 0) begin
      cmd_take(v, cd);
      chk("R4 cmd valid", 32'(v), 32'd1);
      chk("R4 cmd data", 32'(cd), 32'(cq.pop_front()));
    end
    cmd_take(v, cd);
    chk("R4 empty no valid", 32'(v), 32'd0);
    rd(6'h34, r); chk("R4 room after empty pop", r, exp_room(0));

    // R3 overflow drop
    for (int i = 0; i < 20; i++) begin
      wr(6'h38, 32'(i));
      if (cq.size() < D) cq.push_back(16'(i));
    end
    rd(6'h34, r); chk("R3 cmd room full", r, 32'd0);
    while (cq.size() > 0) begin
      cmd_take(v, cd);
      chk("R3 kept entries", 32'(cd), 32'(cq.pop_front()));
    end

    // R3 / R4 random command traffic
    for (int it = 0; it < 300; it++) begin
      int sel = int'($urandom % 3);
      if (sel < 2) begin
        logic [15:0] val = 16'($urandom);
        wr(6'h38, {16'hFFFF, val});
        if (cq.size() < D) cq.push_back(val);
      end else begin
        cmd_take(v, cd);
        if (cq.size() > 0) chk("R4 random cmd data", 32'(cd), 32'(cq.pop_front()));
        else chk("R4 random empty", 32'(v), 32'd0);
      end
      if (it % 10 == 9) begin
        rd(6'h34, r); chk("R3 random cmd room", r, exp_room(cq.size()));
      end
    end
    while (cq.size() > 0) begin
      cmd_take(v, cd);
      chk("R4 drain", 32'(cd), 32'(cq.pop_front()));
    end

    // R4 transmit path
    wr(6'h39, 32'hDEAD_0001);
    wr(6'h39, 32'hBEEF_0002);
    rd(6'h35, r); chk("R3 tx room", r, exp_room(2));
    @(negedge clk); chk("R4 tx head", tx_data, 32'hDEAD_0001); tx_rd = 1'b1;
    @(negedge clk); tx_rd = 1'b0; chk("R4 tx second", tx_data, 32'hBEEF_0002);
    tx_rd = 1'b1;
    @(negedge clk); tx_rd = 1'b0; chk("R4 tx empty", 32'(tx_valid), 32'd0);

    // R5 receive pop/peek
    rd(6'h3A, r); chk("R5 empty pop", r, 32'd0);
    rd(6'h3B, r); chk("R5 empty peek", r, 32'd0);
    for (int i = 0; i < 12; i++) begin
      logic [31:0] val = $urandom;
      rx_put(val); rq.push_back(val);
    end
    rd(6'h36, r); chk("R3 rx level", r, 32'd12);
    idle(1);
    rd(6'h21, r); chk("R6 rx high", r & 32'h4, 32'h4);
    rd(6'h3B, r); chk("R5 peek", r, rq[0]);
    rd(6'h3B, r); chk("R5 peek repeat", r, rq[0]);
    rd(6'h36, r); chk("R5 level after peek", r, 32'd12);
    rd(6'h3A, r); chk("R5 pop", r, rq.pop_front());
    idle(1);
    wr(6'h21, 32'h4);
    idle(2);
    rd(6'h21, r); chk("R7 rx bit cleared", r & 32'h4, 32'h0);
    for (int it = 0; it < 120; it++) begin
      if ($urandom % 2 == 0) begin
        logic [31:0] val = $urandom;
        rx_put(val);
        if (rq.size() < D) rq.push_back(val);
      end else begin
        rd(6'h3A, r);
        if (rq.size() > 0) chk("R5 random pop", r, rq.pop_front());
        else chk("R5 random empty", r, 32'd0);
      end
      if (it % 10 == 9) begin
        rd(6'h36, r); chk("R3 random rx level", r, 32'(rq.size()));
      end
    end

    // R10 sync
    @(negedge clk); sync_evt = 1'b1; sync_id = 8'hA5;
    @(negedge clk); sync_evt = 1'b0; sync_id = 8'h00;
    rd(6'h30, r); chk("R10 sync id", r, 32'hA5);
    rd(6'h21, r); chk("R10 sync pending", r & 32'h8, 32'h8);
    wr(6'h20, 32'h8);
    idle(3);
    chk("R9 irq on sync", 32'(irq), 32'd1);
    wr(6'h21, 32'h8);
    idle(2);
    rd(6'h22, r); chk("R7 sync cleared", r, 32'h0);
    idle(2);
    chk("R9 irq after clear", 32'(irq), 32'd0);

    // R2 soft reset flushes held data
    wr(6'h38, 32'h77);
    wr(6'h39, 32'h88);
    rx_put(32'h99);
    wr(6'h10, 32'd1);
    chk("R2 eng_reset set", 32'(eng_reset), 32'd1);
    wr(6'h10, 32'd0);
    rd(6'h34, r); chk("R2 cmd flushed", r, exp_room(0));
    rd(6'h35, r); chk("R2 tx flushed", r, exp_room(0));
    rd(6'h36, r); chk("R2 rx flushed", r, 32'd0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule